// File: doc/BRIEF.md
# Filtered Sub-band Serial Link

This block is the master end of a three-wire serial link that carries 24-bit stereo sub-band samples between a filter/codec core and a companion processor. It divides the system clock down to a bit clock and divides that by 64 to form a word select at the sample rate. In every word-select period it moves one left word, while word select is low, and one right word, while word select is high. It also drives a frame sync that marks the one period in every 32 that carries sub-band 0.

A direction input selects the mode. In transmit mode the block takes parallel words from the core through a one-cycle take strobe and shifts them out MSB first. In receive mode it samples the incoming data line on rising bit-clock edges and hands each completed word to the core with a channel flag and a valid strobe. A driver-enable output tells the pad whether the data line is driven.

Each half of a word-select period has 32 bit slots, numbered 0 to 31 from the falling bit-clock edge on which word select changes. Slot 1 carries the MSB and slot 24 carries the LSB. Slot 0 and slots 25 to 31 carry no data.

Top module: `fsub_link`

## Requirements
- R1: While rst_n is low, and until the first clock edge after it is released: bclk=0, ws=0, fsync=1, sd_out=0, sd_oe=0, tx_take=0 and rx_valid=0.
- R2: bclk toggles every DIV_HALF system clocks, first rising DIV_HALF clocks after reset release. ws stays 0 for 32 bit-clock periods and then 1 for 32, so a full period holds 64 slots.
- R3: ws, sd_out and fsync change only on the system clock edge on which bclk falls.
- R4: In transmit mode the word for each half is sent MSB first. Bit 23 is in slot 1 and bit 0 is in slot 24. The left word is sent while ws=0 and the right word while ws=1. sd_out is 0 in slot 0 and in slots 25 to 31.
- R5: tx_take is a one-cycle pulse. It goes high in the cycle after the falling bclk edge that starts slot 1, which is the edge on which tx_word is captured. The core then presents the next word, and words alternate left and right starting with left.
- R6: A period counter advances at each ws period boundary and wraps from 31 to 0. fsync is 1 for the whole period whose count is 0 and 0 otherwise.
- R7: In receive mode sd_in is sampled on rising bclk in slots 1 to 24, MSB first. On the falling edge that ends slot 31 of each half, rx_valid pulses for one cycle with rx_word and rx_chan (0 for left, 1 for right).
- R8: In receive mode the value of sd_in during slot 0 and slots 25 to 31 has no effect on rx_word.
- R9: When tx_dir=1, sd_oe is 1 after the first falling bclk and rx_valid never pulses. When tx_dir=0, sd_oe=0, sd_out=0 and tx_take never pulses.
- R10: Asserting rst_n low in mid-stream returns every output to its R1 value at once, and the timing restarts from slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_dir | input | 1 | 1 = transmit, 0 = receive |
| tx_word | input | WORD_W | Next word to send, captured at the start of slot 1 |
| tx_take | output | 1 | One-cycle strobe: tx_word was just captured |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe: rx_word and rx_chan are new |
| rx_chan | output | 1 | Channel of rx_word, 0 left, 1 right |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 left half, 1 right half |
| fsync | output | 1 | High during the period carrying sub-band 0 |
| sd_out | output | 1 | Serial data toward the pad |
| sd_oe | output | 1 | Driver enable for the data pad |
| sd_in | input | 1 | Serial data from the pad |

## Verification
The assertions assume that tx_dir changes only while reset is held, because the enable and strobe checks relate registered state to the live direction input. The bench keeps tx_dir constant within each run and changes it only together with a reset. It holds tx_word stable between captures, and it drives sd_in at the falling system-clock edge, so each bit is settled before the rising bit-clock sample point. In the ignored slots of receive mode, the bench drives a toggling pattern on sd_in, so any capture outside slots 1 to 24 would corrupt the received word.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } bclk_evt_s;
endpackage

// File: rtl/fsl_timebase.sv
module fsl_timebase
   import fsl_pkg::*;
#(
   parameter int DIV_HALF   = 2,
   parameter int SLOTS_HALF = 32,
   parameter int BANDS      = 32,
   localparam int POS_W     = $clog2(2 * SLOTS_HALF),
   localparam int BAND_W    = $clog2(BANDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   output bclk_evt_s         evt,
   output logic              bclk,
   output logic [POS_W-1:0]  pos,
   output logic [POS_W-1:0]  pos_nxt,
   output logic [BAND_W-1:0] band
);
   localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(2 * SLOTS_HALF - 1);
   localparam logic [BAND_W-1:0] BAND_LAST = BAND_W'(BANDS - 1);

   logic edge_now;
   logic bclk_q;
   logic [POS_W-1:0]  pos_q;
   logic [BAND_W-1:0] band_q;

   generate
      if (DIV_HALF == 1) begin : g_div_direct
         assign edge_now = 1'b1;
      end else begin : g_div_count
         localparam int DW = $clog2(DIV_HALF);
         localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (div_q == DIV_LAST) div_q <= '0;
            else                       div_q <= div_q + 1'b1;
         end
         assign edge_now = (div_q == DIV_LAST);
      end
   endgenerate

   assign evt.rise = edge_now & ~bclk_q;
   assign evt.fall = edge_now &  bclk_q;
   assign pos_nxt  = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         pos_q  <= '0;
         band_q <= '0;
      end else begin
         if (edge_now) bclk_q <= ~bclk_q;
         if (evt.fall) begin
            pos_q <= pos_nxt;
            if (pos_q == POS_LAST)
               band_q <= (band_q == BAND_LAST) ? '0 : band_q + 1'b1;
         end
      end
   end

   assign bclk = bclk_q;
   assign pos  = pos_q;
   assign band = band_q;
endmodule

// File: rtl/fsl_tx.sv
module fsl_tx #(
   parameter int WORD_W     = 24,
   parameter int SLOTS_HALF = 32,
   localparam int HW        = $clog2(SLOTS_HALF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  logic              dir_tx,
   input  logic [HW-1:0]     nxt_h,
   input  logic [WORD_W-1:0] word,
   output logic              take,
   output logic              sd,
   output logic              oe
);
   localparam logic [HW-1:0] FIRST_SLOT = HW'(1);
   localparam logic [HW-1:0] LAST_SLOT  = HW'(WORD_W);

   logic [WORD_W-1:0] sr_q;
   logic sd_q, oe_q, take_q;
   logic in_word;

   assign in_word = (nxt_h >= FIRST_SLOT) && (nxt_h <= LAST_SLOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         sd_q   <= 1'b0;
         oe_q   <= 1'b0;
         take_q <= 1'b0;
      end else begin
         take_q <= fall && dir_tx && (nxt_h == FIRST_SLOT);
         if (fall) begin
            oe_q <= dir_tx;
            if (nxt_h == FIRST_SLOT) begin
               sr_q <= word;
               sd_q <= dir_tx & word[WORD_W-1];
            end else if (in_word) begin
               sr_q <= {sr_q[WORD_W-2:0], 1'b0};
               sd_q <= dir_tx & sr_q[WORD_W-2];
            end else begin
               sd_q <= 1'b0;
            end
         end
      end
   end

   assign take = take_q;
   assign sd   = sd_q;
   assign oe   = oe_q;
endmodule

// File: rtl/fsl_rx.sv
module fsl_rx
   import fsl_pkg::*;
#(
   parameter int WORD_W     = 24,
   parameter int SLOTS_HALF = 32,
   localparam int HW        = $clog2(SLOTS_HALF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              dir_tx,
   input  logic [HW-1:0]     cur_h,
   input  chan_e             cur_chan,
   input  logic              sd,
   output logic              valid,
   output chan_e             chan,
   output logic [WORD_W-1:0] word
);
   localparam logic [HW-1:0] FIRST_SLOT = HW'(1);
   localparam logic [HW-1:0] LAST_SLOT  = HW'(WORD_W);
   localparam logic [HW-1:0] END_SLOT   = HW'(SLOTS_HALF - 1);

   logic [WORD_W-1:0] sr_q, word_q;
   logic  valid_q;
   chan_e chan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= '0;
         word_q  <= '0;
         valid_q <= 1'b0;
         chan_q  <= CH_LEFT;
      end else begin
         valid_q <= 1'b0;
         if (rise && (cur_h >= FIRST_SLOT) && (cur_h <= LAST_SLOT))
            sr_q <= {sr_q[WORD_W-2:0], sd};
         if (fall && (cur_h == END_SLOT) && !dir_tx) begin
            valid_q <= 1'b1;
            word_q  <= sr_q;
            chan_q  <= cur_chan;
         end
      end
   end

   assign valid = valid_q;
   assign chan  = chan_q;
   assign word  = word_q;
endmodule

// File: rtl/fsub_link.sv
module fsub_link
   import fsl_pkg::*;
#(
   parameter int WORD_W     = 24,
   parameter int SLOTS_HALF = 32,
   parameter int BANDS      = 32,
   parameter int DIV_HALF   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_dir,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_take,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              rx_chan,
   output logic              bclk,
   output logic              ws,
   output logic              fsync,
   output logic              sd_out,
   output logic              sd_oe,
   input  logic              sd_in
);
   localparam int POS_W  = $clog2(2 * SLOTS_HALF);
   localparam int HW     = $clog2(SLOTS_HALF);
   localparam int BAND_W = $clog2(BANDS);

   generate
      if (WORD_W < 2 || WORD_W > SLOTS_HALF - 1) begin : g_bad_word
         $error("WORD_W must be in 2..SLOTS_HALF-1");
      end
      if (SLOTS_HALF < 2 || (1 << HW) != SLOTS_HALF) begin : g_bad_slots
         $error("SLOTS_HALF must be a power of two, at least 2");
      end
      if (BANDS < 2) begin : g_bad_bands
         $error("BANDS must be at least 2");
      end
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
   endgenerate

   bclk_evt_s         evt;
   logic [POS_W-1:0]  pos, pos_nxt;
   logic [BAND_W-1:0] band;
   chan_e             rx_chan_e;
   chan_e             cur_chan;

   fsl_timebase #(
      .DIV_HALF  (DIV_HALF),
      .SLOTS_HALF(SLOTS_HALF),
      .BANDS     (BANDS)
   ) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .bclk   (bclk),
      .pos    (pos),
      .pos_nxt(pos_nxt),
      .band   (band)
   );

   assign cur_chan = chan_e'(pos[POS_W-1]);

   fsl_tx #(
      .WORD_W    (WORD_W),
      .SLOTS_HALF(SLOTS_HALF)
   ) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .fall  (evt.fall),
      .dir_tx(tx_dir),
      .nxt_h (pos_nxt[HW-1:0]),
      .word  (tx_word),
      .take  (tx_take),
      .sd    (sd_out),
      .oe    (sd_oe)
   );

   fsl_rx #(
      .WORD_W    (WORD_W),
      .SLOTS_HALF(SLOTS_HALF)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (evt.rise),
      .fall    (evt.fall),
      .dir_tx  (tx_dir),
      .cur_h   (pos[HW-1:0]),
      .cur_chan(cur_chan),
      .sd      (sd_in),
      .valid   (rx_valid),
      .chan    (rx_chan_e),
      .word    (rx_word)
   );

   assign rx_chan = rx_chan_e;
   assign ws      = pos[POS_W-1];
   assign fsync   = (band == '0);
endmodule

// File: rtl/fsub_link_chk.sv
module fsub_link_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_dir,
   input logic tx_take,
   input logic rx_valid,
   input logic bclk,
   input logic ws,
   input logic fsync,
   input logic sd_out,
   input logic sd_oe
);
   // R3: word select moves only with a falling bit clock
   assert_ws_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ws) |-> $fell(bclk));
   // R3: data moves only with a falling bit clock
   assert_sd_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sd_out) |-> $fell(bclk));
   // R6: sync starts together with a left half
   assert_fsync_at_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> $fell(ws));
   // R5: take strobe lasts one cycle and follows a falling bit clock
   assert_take_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |=> !tx_take);
   assert_take_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> $fell(bclk));
   // R7: valid strobe lasts one cycle
   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R9: no receive strobe while transmitting, no drive while receiving
   assert_no_rx_in_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !tx_dir);
   assert_quiet_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_oe |-> !sd_out);
endmodule

bind fsub_link fsub_link_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tx_dir  (tx_dir),
   .tx_take (tx_take),
   .rx_valid(rx_valid),
   .bclk    (bclk),
   .ws      (ws),
   .fsync   (fsync),
   .sd_out  (sd_out),
   .sd_oe   (sd_oe)
);

// File: tb/sim_fsub_link.sv
module sim_fsub_link;
   localparam int W = 24;
   localparam int D = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_dir = 1'b1;
   logic [W-1:0] tx_word;
   logic sd_in = 1'b0;
   logic tx_take, rx_valid, rx_chan, bclk, ws, fsync, sd_out, sd_oe;
   logic [W-1:0] rx_word;

   int k = 0;
   int checks = 0;
   int failures = 0;
   bit done = 0;
   string phase_tag = "R1";
   int prev_ws = 0;
   int prev_sd = 0;
   int prev_fs = 1;

   always #5 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) k <= 0;
      else        k <= k + 1;
   end

   fsub_link u0 (
      .clk(clk), .rst_n(rst_n), .tx_dir(tx_dir), .tx_word(tx_word),
      .tx_take(tx_take), .rx_word(rx_word), .rx_valid(rx_valid),
      .rx_chan(rx_chan), .bclk(bclk), .ws(ws), .fsync(fsync),
      .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
   );

   function automatic logic [W-1:0] gen_tx(int m);
      return W'((m * 32'h009E3779) ^ 32'h005A5A5A ^ (m << 13));
   endfunction

   function automatic logic [W-1:0] gen_rx(int m);
      return W'((m * 32'h0001F3A5) ^ 32'h00C3B1E7 ^ (m << 9));
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s at k=%0d: actual=%0h expected=%0h", req, what, k, act, exp);
      end
   endtask

   task automatic step();
      int t, pos, h, band, m, nxt;
      bit fell_now, e_ws, e_take, e_valid;
      int e_sd, e_oe;
      @(negedge clk);
      t    = k / (2 * D);
      pos  = t % 64;
      h    = pos % 32;
      band = (t / 64) % 32;
      m    = t / 32;
      fell_now = (k > 0) && (k % (2 * D) == 0);
      e_ws = (pos >= 32);
      e_oe = (t >= 1) ? int'(tx_dir) : 0;
      e_sd = 0;
      if (tx_dir && t >= 1 && h >= 1 && h <= W) e_sd = int'(gen_tx(m)[W - h]);
      e_take  = tx_dir && fell_now && (h == 1);
      e_valid = !tx_dir && fell_now && (h == 0) && (t > 0);

      if (!rst_n || k == 0) begin
         chk(phase_tag, "bclk", bclk, 0);
         chk(phase_tag, "ws", ws, 0);
         chk(phase_tag, "fsync", fsync, 1);
         chk(phase_tag, "sd_out", sd_out, 0);
         chk(phase_tag, "sd_oe", sd_oe, 0);
         chk(phase_tag, "tx_take", tx_take, 0);
         chk(phase_tag, "rx_valid", rx_valid, 0);
      end else begin
         chk("R2", "bclk", bclk, (k / D) % 2);
         chk("R2", "ws", ws, int'(e_ws));
         chk("R6", "fsync", fsync, int'(band == 0));
         chk("R4", "sd_out", sd_out, e_sd);
         chk("R9", "sd_oe", sd_oe, e_oe);
         chk(tx_dir ? "R5" : "R9", "tx_take", tx_take, int'(e_take));
         chk(tx_dir ? "R9" : "R7", "rx_valid", rx_valid, int'(e_valid));
         if (e_valid && rx_valid) begin
            chk("R7 R8", "rx_word", int'(rx_word), int'(gen_rx(m - 1)));
            chk("R7", "rx_chan", rx_chan, int'(!e_ws));
         end
         if (!fell_now) begin
            chk("R3", "ws hold", ws, prev_ws);
            chk("R3", "sd_out hold", sd_out, prev_sd);
            chk("R3", "fsync hold", fsync, prev_fs);
         end
      end
      prev_ws = ws;
      prev_sd = sd_out;
      prev_fs = fsync;

      nxt = (h >= 1) ? m + 1 : m;
      tx_word = gen_tx(nxt);
      if (h >= 1 && h <= W) sd_in = gen_rx(m)[W - h];
      else                  sd_in = ((k >> 1) & 1) ^ (h & 1);
   endtask

   initial begin
      tx_word = gen_tx(0);
      // R1: reset state while held
      phase_tag = "R1";
      tx_dir = 1'b1;
      for (int i = 0; i < 5; i++) step();
      rst_n = 1'b1;
      // transmit run across a full sync cycle and its wrap
      for (int i = 0; i < 34 * 64 * 2 * D + 40; i++) step();
      // R10: asynchronous reset in mid-stream, then receive mode
      #2 rst_n = 1'b0;
      phase_tag = "R10";
      tx_dir = 1'b0;
      for (int i = 0; i < 3; i++) step();
      rst_n = 1'b1;
      for (int i = 0; i < 5 * 64 * 2 * D + 20; i++) step();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired at k=%0d", k);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule